// File: doc/BRIEF.md
# Serial Command Frame Target with Length Check and Interrupt

This block is the target side of a four-wire serial link that carries fixed 32-bit command words. It samples the select, serial clock and serial data lines with a fast system clock. Every pin passes through a synchronizer, and edges are found on the synchronized copies. During each select-low window the block shifts one command word in and one response word out, both most significant bit first. The response word is a copy of the interrupt status, taken when select falls.

When select rises, the block counts the bits it took in. A frame of exactly 32 bits becomes a one-cycle write or read strobe to a register file, with the decoded address and write data. A frame of any other non-zero length is discarded. It sets the link-failure flag, and that flag drives the active-low interrupt line. A valid read of the status address clears the flag and releases the interrupt.

Top module: `spi_frame_ctrl`

## Requirements
- R1: During and after reset, the outputs are idle: `so_oe_o`=0, `irq_n_o`=1, `wr_stb_o`=0 and `rd_stb_o`=0. The failure flag is clear.
- R2: Serial input is captured on falling serial clock edges, first bit is bit 31. A 32-bit frame with bit 31 = 1 is a write. It gives exactly one one-cycle `wr_stb_o` after select rises, with `reg_addr_o` = bits 30:25 and `reg_wdata_o` = bits 24:0.
- R3: A 32-bit frame with bit 31 = 0 is a read. It gives exactly one one-cycle `rd_stb_o` with `reg_addr_o` = bits 30:25 and no write strobe. The two strobes are never high together.
- R4: A falling select enables the output (`so_oe_o`=1) and drives `so_o` high before any serial clock edge.
- R5: Each rising serial clock edge presents the next response bit, starting with bit 31. The response word is the status snapshot taken at select fall: bits 31:1 are zero and bit 0 is the failure flag.
- R6: A frame of 1 to 31 bits, or of more than 32 bits, produces no strobe. At select rise it sets the failure flag and drives `irq_n_o` low.
- R7: A select-low window with no serial clock edge produces no strobe and leaves the failure flag and `irq_n_o` unchanged.
- R8: A rising select disables the output (`so_oe_o`=0) before any strobe of that frame appears.
- R9: A valid read of address `STAT_ADDR` (default 0) clears the failure flag and returns `irq_n_o` high at the same time as its `rd_stb_o`. A read of any other address leaves `irq_n_o` unchanged.
- R10: Serial clock and data activity while select is high is ignored. It gives no strobe, the output stays disabled, and it does not alter the bit count of the next frame.
- R11: The bit counter saturates above 32, so a frame of 40 bits is still treated as a length failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Select, active low, asynchronous |
| sck_i | input | 1 | Serial clock, asynchronous |
| si_i | input | 1 | Serial data in, asynchronous |
| so_o | output | 1 | Serial data out value |
| so_oe_o | output | 1 | Serial data out driver enable |
| irq_n_o | output | 1 | Interrupt, active low |
| wr_stb_o | output | 1 | One-cycle register write strobe |
| rd_stb_o | output | 1 | One-cycle register read strobe |
| reg_addr_o | output | 6 | Register address of the last valid frame |
| reg_wdata_o | output | 25 | Write data of the last valid write frame |

## Verification
The hardest states to reach are the ones where the interrupt and the response word depend on earlier frames. Examples are a status read that must return a set failure bit, a read of another address that must leave the interrupt low, and an overlong frame that must not wrap the counter. The stimulus table chains frames so that each entry starts from the status the one before it left. Short, 40-bit and clock-less frames alternate with status reads, and the bench checks the sampled response bit 0 against the interrupt level it expected at the previous frame's end. Serial clock toggling while select is high comes just before a valid frame, to show that the count is not disturbed.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;

    localparam int CMD_W  = 32;
    localparam int ADDR_W = 6;
    localparam int DATA_W = CMD_W - 1 - ADDR_W;
    localparam int CNT_W  = $clog2(CMD_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CMD_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(CMD_W + 1);

    typedef enum logic [1:0] {
        VERD_EMPTY = 2'd0,
        VERD_OK    = 2'd1,
        VERD_BAD   = 2'd2
    } verdict_e;

    typedef struct packed {
        logic              is_wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [CMD_W-1:0] w);
        cmd_t c;
        c.is_wr = w[CMD_W-1];
        c.addr  = w[CMD_W-2 -: ADDR_W];
        c.data  = w[DATA_W-1:0];
        return c;
    endfunction

    function automatic verdict_e judge_len(input logic [CNT_W-1:0] n);
        if (n == '0)
            return VERD_EMPTY;
        else if (n == CNT_FULL)
            return VERD_OK;
        else
            return VERD_BAD;
    endfunction

    function automatic logic [CNT_W-1:0] bump_sat(input logic [CNT_W-1:0] n);
        return (n == CNT_SAT) ? n : n + 1'b1;
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RST_VAL;
                    else     chain[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= RST_VAL;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
    import spi_frame_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_s,
    input  logic             sck_s,
    input  logic             si_s,
    input  logic [CMD_W-1:0] snap_i,
    output logic             so_o,
    output logic             so_oe_o,
    output logic             done_o,
    output verdict_e         verdict_o,
    output cmd_t             cmd_o
);
    logic             cs_d, sck_d;
    logic [CNT_W-1:0] cnt;
    logic [CMD_W-1:0] rx_sh, tx_sh;
    logic             cs_fall, cs_rise, sck_rise, sck_fall, in_frame;

    always_comb begin
        cs_fall  = cs_d & ~cs_s;
        cs_rise  = ~cs_d & cs_s;
        in_frame = ~cs_d & ~cs_s;
        sck_rise = ~sck_d & sck_s;
        sck_fall = sck_d & ~sck_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_d      <= 1'b1;
            sck_d     <= 1'b0;
            cnt       <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            so_o      <= 1'b1;
            so_oe_o   <= 1'b0;
            done_o    <= 1'b0;
            verdict_o <= VERD_EMPTY;
            cmd_o     <= '0;
        end else begin
            cs_d   <= cs_s;
            sck_d  <= sck_s;
            done_o <= 1'b0;
            if (cs_fall) begin
                cnt     <= '0;
                tx_sh   <= snap_i;
                so_oe_o <= 1'b1;
                so_o    <= 1'b1;
            end else if (cs_rise) begin
                so_oe_o   <= 1'b0;
                so_o      <= 1'b1;
                done_o    <= 1'b1;
                verdict_o <= judge_len(cnt);
                cmd_o     <= decode_cmd(rx_sh);
            end else if (in_frame) begin
                if (sck_rise) begin
                    so_o  <= tx_sh[CMD_W-1];
                    tx_sh <= {tx_sh[CMD_W-2:0], 1'b0};
                end
                if (sck_fall) begin
                    rx_sh <= {rx_sh[CMD_W-2:0], si_s};
                    cnt   <= bump_sat(cnt);
                end
            end
        end
    end
endmodule

// File: rtl/frame_commit.sv
module frame_commit
    import spi_frame_pkg::*;
#(
    parameter logic [ADDR_W-1:0] STAT_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              done_i,
    input  verdict_e          verdict_i,
    input  cmd_t              cmd_i,
    output logic              wr_stb_o,
    output logic              rd_stb_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              fail_o,
    output logic              irq_n_o
);
    logic ok_frame, bad_frame, stat_read;

    always_comb begin
        ok_frame  = done_i && (verdict_i == VERD_OK);
        bad_frame = done_i && (verdict_i == VERD_BAD);
        stat_read = ok_frame && !cmd_i.is_wr && (cmd_i.addr == STAT_ADDR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_stb_o <= 1'b0;
            rd_stb_o <= 1'b0;
            addr_o   <= '0;
            wdata_o  <= '0;
            fail_o   <= 1'b0;
            irq_n_o  <= 1'b1;
        end else begin
            wr_stb_o <= ok_frame && cmd_i.is_wr;
            rd_stb_o <= ok_frame && !cmd_i.is_wr;
            if (ok_frame) begin
                addr_o <= cmd_i.addr;
                if (cmd_i.is_wr) wdata_o <= cmd_i.data;
            end
            if (bad_frame) begin
                fail_o  <= 1'b1;
                irq_n_o <= 1'b0;
            end else if (stat_read) begin
                fail_o  <= 1'b0;
                irq_n_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
    import spi_frame_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] STAT_ADDR   = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_i,
    input  logic              sck_i,
    input  logic              si_i,
    output logic              so_o,
    output logic              so_oe_o,
    output logic              irq_n_o,
    output logic              wr_stb_o,
    output logic              rd_stb_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [DATA_W-1:0] reg_wdata_o
);
    logic             cs_s, sck_s, si_s;
    logic             done, fail;
    verdict_e         verdict;
    cmd_t             cmd;
    logic [CMD_W-1:0] snap;

    pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_cs (
        .clk(clk), .rst(rst), .d_i(cs_n_i), .q_o(cs_s));
    pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_sck (
        .clk(clk), .rst(rst), .d_i(sck_i), .q_o(sck_s));
    pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_si (
        .clk(clk), .rst(rst), .d_i(si_i), .q_o(si_s));

    assign snap = {{(CMD_W-1){1'b0}}, fail};

    frame_shifter i_shift (
        .clk(clk), .rst(rst), .cs_s(cs_s), .sck_s(sck_s), .si_s(si_s),
        .snap_i(snap), .so_o(so_o), .so_oe_o(so_oe_o),
        .done_o(done), .verdict_o(verdict), .cmd_o(cmd));

    frame_commit #(.STAT_ADDR(STAT_ADDR)) i_commit (
        .clk(clk), .rst(rst), .done_i(done), .verdict_i(verdict), .cmd_i(cmd),
        .wr_stb_o(wr_stb_o), .rd_stb_o(rd_stb_o), .addr_o(reg_addr_o),
        .wdata_o(reg_wdata_o), .fail_o(fail), .irq_n_o(irq_n_o));
endmodule

// File: rtl/spi_frame_chk.sv
module spi_frame_chk
    import spi_frame_pkg::*;
#(
    parameter logic [ADDR_W-1:0] STAT_ADDR = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              so_o,
    input logic              so_oe_o,
    input logic              irq_n_o,
    input logic              wr_stb_o,
    input logic              rd_stb_o,
    input logic [ADDR_W-1:0] reg_addr_o
);
    assert_no_dual_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        !(wr_stb_o && rd_stb_o));

    assert_wr_single_cycle_R2: assert property (@(posedge clk) disable iff (rst)
        wr_stb_o |=> !wr_stb_o);

    assert_enable_drives_high_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(so_oe_o) |-> so_o);

    assert_strobe_after_disable_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_stb_o || rd_stb_o) |-> !so_oe_o);

    assert_bad_frame_no_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_n_o) |-> (!wr_stb_o && !rd_stb_o));

    assert_release_on_stat_read_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_n_o) |-> (rd_stb_o && reg_addr_o == STAT_ADDR));
endmodule

bind spi_frame_ctrl spi_frame_chk #(.STAT_ADDR(STAT_ADDR)) i_chk (
    .clk(clk), .rst(rst), .so_o(so_o), .so_oe_o(so_oe_o), .irq_n_o(irq_n_o),
    .wr_stb_o(wr_stb_o), .rd_stb_o(rd_stb_o), .reg_addr_o(reg_addr_o));

// File: tb/test_spi_frame_ctrl.sv
module test_spi_frame_ctrl;
    localparam int HALF = 13;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sck = 1'b0;
    logic        si = 1'b0;
    logic        so, so_oe, irq_n, wr_stb, rd_stb;
    logic [5:0]  addr;
    logic [24:0] wdata;

    int checks = 0;
    int fails = 0;
    int wr_seen = 0;
    int rd_seen = 0;
    bit done = 0;

    always #5 clk = ~clk;

    spi_frame_ctrl i_spi_frame_ctrl (
        .clk(clk), .rst(rst), .cs_n_i(cs_n), .sck_i(sck), .si_i(si),
        .so_o(so), .so_oe_o(so_oe), .irq_n_o(irq_n),
        .wr_stb_o(wr_stb), .rd_stb_o(rd_stb),
        .reg_addr_o(addr), .reg_wdata_o(wdata));

    always @(negedge clk) begin
        if (!rst && wr_stb) wr_seen++;
        if (!rst && rd_stb) rd_seen++;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        #(n * 10);
    endtask

    // Sends nbits bits of word, MSB first; bits beyond 32 are zero.
    task automatic send_frame(input int nbits, input logic [31:0] word,
                              output logic [31:0] resp);
        resp = '0;
        cs_n = 1'b0;
        wait_clk(HALF);
        chk(so_oe == 1'b1, "R4 enable", 64'(so_oe), 64'd1);
        chk(so == 1'b1, "R4 idle high", 64'(so), 64'd1);
        for (int i = 0; i < nbits; i++) begin
            sck = 1'b1;
            si  = (i < 32) ? word[31-i] : 1'b0;
            wait_clk(HALF);
            if (i < 32) resp[31-i] = so;
            sck = 1'b0;
            wait_clk(HALF);
        end
        cs_n = 1'b1;
        wait_clk(2 * HALF);
        chk(so_oe == 1'b0, "R8 disable", 64'(so_oe), 64'd0);
    endtask

    // {nbits[5:0], word[31:0], exp_wr, exp_rd, exp_irq_n}
    localparam int NV = 12;
    localparam logic [40:0] VEC [NV] = '{
        {6'd32, 32'h8B5A_BCDE, 1'b1, 1'b0, 1'b1},
        {6'd32, 32'h1200_0000, 1'b0, 1'b1, 1'b1},
        {6'd31, 32'h8600_0001, 1'b0, 1'b0, 1'b0},
        {6'd32, 32'h8601_2345, 1'b1, 1'b0, 1'b0},
        {6'd32, 32'h0E00_0000, 1'b0, 1'b1, 1'b0},
        {6'd32, 32'h0000_0000, 1'b0, 1'b1, 1'b1},
        {6'd40, 32'h8200_0007, 1'b0, 1'b0, 1'b0},
        {6'd32, 32'h0000_0000, 1'b0, 1'b1, 1'b1},
        {6'd0,  32'h0000_0000, 1'b0, 1'b0, 1'b1},
        {6'd1,  32'h8000_0000, 1'b0, 1'b0, 1'b0},
        {6'd0,  32'h0000_0000, 1'b0, 1'b0, 1'b0},
        {6'd32, 32'h0000_0000, 1'b0, 1'b1, 1'b1}
    };

    initial begin
        logic [31:0] resp;
        logic        irq_prev;
        #3;
        wait_clk(2);
        chk(so_oe == 1'b0 && irq_n == 1'b1 && wr_stb == 1'b0 && rd_stb == 1'b0,
            "R1 during reset", {60'd0, so_oe, irq_n, wr_stb, rd_stb}, 64'h4);
        wait_clk(3);
        rst = 1'b0;
        wait_clk(5);
        chk(so_oe == 1'b0 && irq_n == 1'b1 && wr_seen == 0 && rd_seen == 0,
            "R1 after reset", {62'd0, so_oe, irq_n}, 64'h1);

        // R10: clock and data toggling with select high
        for (int k = 0; k < 10; k++) begin
            sck = 1'b1; si = k[0];
            wait_clk(HALF);
            sck = 1'b0;
            wait_clk(HALF);
        end
        si = 1'b0;
        chk(wr_seen == 0 && rd_seen == 0, "R10 no strobe", 64'(wr_seen + rd_seen), 64'd0);
        chk(so_oe == 1'b0, "R10 output stays off", 64'(so_oe), 64'd0);

        // stimulus table
        for (int v = 0; v < NV; v++) begin
            int          nb;
            logic [31:0] w;
            logic        ew, er, ei;
            int          w0, r0;
            nb = int'(VEC[v][40:35]);
            w  = VEC[v][34:3];
            ew = VEC[v][2];
            er = VEC[v][1];
            ei = VEC[v][0];
            w0 = wr_seen;
            r0 = rd_seen;
            irq_prev = irq_n;
            send_frame(nb, w, resp);
            if (nb >= 32)
                chk(resp == {31'd0, ~irq_prev}, $sformatf("R5 response v%0d", v),
                    64'(resp), {63'd0, ~irq_prev});
            chk(wr_seen - w0 == int'(ew), $sformatf("R2 write count v%0d", v),
                64'(wr_seen - w0), 64'(ew));
            chk(rd_seen - r0 == int'(er), $sformatf("R3 read count v%0d", v),
                64'(rd_seen - r0), 64'(er));
            if (ew) begin
                chk(addr == w[30:25], $sformatf("R2 addr v%0d", v), 64'(addr), 64'(w[30:25]));
                chk(wdata == w[24:0], $sformatf("R2 data v%0d", v), 64'(wdata), 64'(w[24:0]));
            end
            if (er)
                chk(addr == w[30:25], $sformatf("R3 addr v%0d", v), 64'(addr), 64'(w[30:25]));
            if (nb == 0)
                chk(irq_n == irq_prev, $sformatf("R7 empty frame v%0d", v),
                    64'(irq_n), 64'(irq_prev));
            else if (nb == 40)
                chk(irq_n == ei, "R11 overlong frame", 64'(irq_n), 64'(ei));
            else if (nb != 32)
                chk(irq_n == ei, $sformatf("R6 short frame v%0d", v), 64'(irq_n), 64'(ei));
            else
                chk(irq_n == ei, $sformatf("R9 irq level v%0d", v), 64'(irq_n), 64'(ei));
        end

        // R10: a valid write right after select-high activity is counted exactly
        for (int k = 0; k < 5; k++) begin
            sck = 1'b1; si = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
            wait_clk(HALF);
        end
        si = 1'b0;
        begin
            int w0;
            w0 = wr_seen;
            send_frame(32, 32'hBE00_0055, resp);
            chk(wr_seen - w0 == 1, "R10 next frame intact", 64'(wr_seen - w0), 64'd1);
            chk(addr == 6'h1F && wdata == 25'h55, "R10 next frame fields",
                {32'(addr), 32'(wdata)}, {32'h1F, 32'h55});
            chk(irq_n == 1'b1, "R10 no failure", 64'(irq_n), 64'd1);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule